// File: doc/BRIEF.md
# Cache-Aligned Write Burst Sequencer

This block takes one DMA write request, given as a start byte address and a byte count, and breaks it into a series of bus write bursts. Each burst leaves the block as a command code, a start address and a byte length. If the start address sits inside a cache line, the first burst is an ordinary write that runs up to the next line boundary. The block then issues write-and-invalidate bursts of whole cache lines for as long as enough bytes remain. A single ordinary write finishes the transfer.

Requests arrive on a valid/ready port and bursts leave on a second valid/ready port. A request is accepted only when `req_valid` and `req_ready` are both high at a clock edge. A burst is consumed only when `bst_valid` and `bst_ready` are both high at a clock edge. While `bst_ready` is low, the offered burst stays exactly as it is. The configuration pins are plain levels: burst size, cache line size, invalidate threshold and the two invalidate enables. They are captured when a request is accepted, and changes made later do not affect the transfer in progress.

The line size is `1 << cfg_line_sel` bytes. The next request may be accepted in the same cycle in which the final burst of the current one is consumed, so one transfer follows another with no idle cycle between them.

Top module: `wbs_seq`

## Requirements
- R1: Only two 4-bit command codes ever appear on `bst_cmd`: 0x7 for an ordinary write and 0xF for write-and-invalidate.
- R2: When the start address is not a multiple of the line size, the first burst is 0x7 at the start address, with length min(line − (addr mod line), count). A request that ends before that boundary yields exactly one such burst, and it is flagged last.
- R3: When the start address is a multiple of the line size, no alignment burst is issued.
- R4: The write-and-invalidate length is `cfg_burst_bytes` rounded down to a multiple of the line size. A 0xF burst of that length is issued whenever the address is line-aligned, the remaining count is strictly greater than `cfg_inv_thresh`, and the remaining count is at least that length.
- R5: Once the 0xF condition of R4 fails at an aligned address, a single 0x7 burst covers every remaining byte.
- R6: A 0xF burst requires both `cfg_inv_en_dev` and `cfg_inv_en_bus` to be high. If either is low, the alignment burst of R2 still occurs and every burst is 0x7.
- R7: When the rounded length of R4 is zero, no 0xF burst is issued.
- R8: Consecutive bursts of a request are contiguous, and their lengths add up to the count. `bst_last` is high on the final burst only. If the 0xF bursts use up every byte, no 0x7 burst follows them.
- R9: While `bst_valid` is high and `bst_ready` is low, `bst_cmd`, `bst_addr`, `bst_len` and `bst_last` hold their values and `bst_valid` stays high.
- R10: `req_ready` is high when no transfer is active, and also in a cycle where the final burst is being consumed. A non-empty request accepted in that cycle has its first burst valid in the very next cycle.
- R11: A request with a count of zero is accepted and produces no burst.
- R12: After reset, `bst_valid` is low and `req_ready` is high.
- R13: The configuration pins are sampled when a request is accepted. Changes made during the transfer do not alter its bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | AW | Start byte address |
| req_count | input | CW | Byte count |
| cfg_burst_bytes | input | CW | Programmed burst size in bytes |
| cfg_line_sel | input | LSW | log2 of the cache line size in bytes |
| cfg_inv_thresh | input | CW | Remaining-count threshold for write-and-invalidate |
| cfg_inv_en_dev | input | 1 | Device-side invalidate enable |
| cfg_inv_en_bus | input | 1 | Bus-configuration invalidate enable |
| bst_valid | output | 1 | Burst offered |
| bst_ready | input | 1 | Burst consumer can take it |
| bst_cmd | output | 4 | Command code |
| bst_addr | output | AW | Burst start address |
| bst_len | output | CW | Burst length in bytes |
| bst_last | output | 1 | Final burst of the request |

## Verification
Two events can land in one cycle: the final burst of a transfer is consumed, and the next request is accepted. The bench provokes this by keeping a sequence of requests offered on the request port while it consumes bursts under random back-pressure. In the cycle where the last burst is consumed, it expects `req_ready` to be high. In the cycle that follows, it expects the first burst of the next request, with no gap, and that burst must match the sequence the bench computes for the new request. A zero-count request placed in the same position must be absorbed without producing a burst.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  typedef enum logic [3:0] {
    CMD_MEM_WR     = 4'h7,
    CMD_MEM_WR_INV = 4'hF
  } wcmd_e;

  typedef enum logic [1:0] {
    PH_ALIGN = 2'd0,
    PH_BULK  = 2'd1,
    PH_TAIL  = 2'd2
  } phase_e;

endpackage

// File: rtl/wbs_line_math.sv
module wbs_line_math #(
  parameter int CW  = 16,
  parameter int LSW = 3
) (
  input  logic [LSW-1:0] line_sel,
  input  logic [CW-1:0]  addr_lo,
  input  logic [CW-1:0]  burst_bytes,
  output logic [CW-1:0]  line_mask,
  output logic [CW-1:0]  to_boundary,
  output logic [CW-1:0]  whole_len,
  output logic           misaligned
);
  logic [CW-1:0] line_bytes;
  logic [CW-1:0] offset;

  always_comb begin
    line_bytes  = CW'(1) << line_sel;
    line_mask   = line_bytes - CW'(1);
    offset      = addr_lo & line_mask;
    misaligned  = (offset != '0);
    to_boundary = line_bytes - offset;
    whole_len   = burst_bytes & ~line_mask;
  end
endmodule

// File: rtl/wbs_burst_pick.sv
module wbs_burst_pick #(
  parameter int CW = 16
) (
  input  logic              misaligned,
  input  logic [CW-1:0]     to_boundary,
  input  logic [CW-1:0]     whole_len,
  input  logic [CW-1:0]     remain,
  input  logic [CW-1:0]     thresh,
  input  logic              inv_ok,
  output wbs_pkg::phase_e   phase,
  output wbs_pkg::wcmd_e    cmd,
  output logic [CW-1:0]     len,
  output logic              last
);
  import wbs_pkg::*;

  logic bulk_ok;

  always_comb begin
    bulk_ok = inv_ok && (whole_len != '0) && (remain > thresh) && (remain >= whole_len);
    if (misaligned) begin
      phase = PH_ALIGN;
      cmd   = CMD_MEM_WR;
      len   = (to_boundary < remain) ? to_boundary : remain;
    end else if (bulk_ok) begin
      phase = PH_BULK;
      cmd   = CMD_MEM_WR_INV;
      len   = whole_len;
    end else begin
      phase = PH_TAIL;
      cmd   = CMD_MEM_WR;
      len   = remain;
    end
    last = (len == remain);
  end
endmodule

// File: rtl/wbs_seq.sv
module wbs_seq #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int LSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [CW-1:0]  req_count,
  input  logic [CW-1:0]  cfg_burst_bytes,
  input  logic [LSW-1:0] cfg_line_sel,
  input  logic [CW-1:0]  cfg_inv_thresh,
  input  logic           cfg_inv_en_dev,
  input  logic           cfg_inv_en_bus,
  output logic           bst_valid,
  input  logic           bst_ready,
  output logic [3:0]     bst_cmd,
  output logic [AW-1:0]  bst_addr,
  output logic [CW-1:0]  bst_len,
  output logic           bst_last
);
  import wbs_pkg::*;

  logic           busy;
  logic [AW-1:0]  cur_addr;
  logic [CW-1:0]  remain;
  logic [CW-1:0]  l_burst;
  logic [CW-1:0]  l_thresh;
  logic [LSW-1:0] l_line_sel;
  logic           l_inv_ok;

  logic [CW-1:0]  line_mask;
  logic [CW-1:0]  to_bnd;
  logic [CW-1:0]  whole_len;
  logic           misal;

  phase_e         pick_phase;
  wcmd_e          pick_cmd;
  logic [CW-1:0]  pick_len;
  logic           pick_last;

  logic           req_fire;
  logic           bst_fire;

  wbs_line_math #(.CW(CW), .LSW(LSW)) u_line (
    .line_sel    (l_line_sel),
    .addr_lo     (cur_addr[CW-1:0]),
    .burst_bytes (l_burst),
    .line_mask   (line_mask),
    .to_boundary (to_bnd),
    .whole_len   (whole_len),
    .misaligned  (misal)
  );

  wbs_burst_pick #(.CW(CW)) u_pick (
    .misaligned  (misal),
    .to_boundary (to_bnd),
    .whole_len   (whole_len),
    .remain      (remain),
    .thresh      (l_thresh),
    .inv_ok      (l_inv_ok),
    .phase       (pick_phase),
    .cmd         (pick_cmd),
    .len         (pick_len),
    .last        (pick_last)
  );

  assign bst_valid = busy;
  assign bst_cmd   = pick_cmd;
  assign bst_addr  = cur_addr;
  assign bst_len   = pick_len;
  assign bst_last  = pick_last;

  assign bst_fire  = busy && bst_ready;
  assign req_ready = !busy || (bst_ready && pick_last);
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cur_addr   <= '0;
      remain     <= '0;
      l_burst    <= '0;
      l_thresh   <= '0;
      l_line_sel <= '0;
      l_inv_ok   <= 1'b0;
    end else begin
      if (bst_fire) begin
        cur_addr <= cur_addr + AW'(pick_len);
        remain   <= remain - pick_len;
        if (pick_last) busy <= 1'b0;
      end
      if (req_fire) begin
        busy       <= (req_count != '0);
        cur_addr   <= req_addr;
        remain     <= req_count;
        l_burst    <= cfg_burst_bytes;
        l_thresh   <= cfg_inv_thresh;
        l_line_sel <= cfg_line_sel;
        l_inv_ok   <= cfg_inv_en_dev && cfg_inv_en_bus;
      end
    end
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (bst_cmd == 4'h7 || bst_cmd == 4'hF)); // R1

  AST_ALIGN_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && pick_phase == PH_ALIGN) |-> (bst_cmd == 4'h7 && bst_len <= to_bnd)); // R2

  AST_INV_WHOLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && bst_cmd == 4'hF) |->
      (((bst_len & line_mask) == '0) && ((bst_addr[CW-1:0] & line_mask) == '0)
       && (remain > l_thresh))); // R4

  AST_INV_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && bst_cmd == 4'hF) |-> l_inv_ok); // R6

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (bst_len != '0 && bst_len <= remain)); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_cmd) && $stable(bst_addr)
                                   && $stable(bst_len) && $stable(bst_last))); // R9

  AST_ACCEPT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bst_valid) |-> (bst_ready && bst_last)); // R10

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_count == '0 && !bst_valid) |=> !bst_valid); // R11

endmodule

// File: tb/wbs_seq_bench.sv
`timescale 1ns/1ps
module wbs_seq_bench;
  localparam int AW  = 32;
  localparam int CW  = 16;
  localparam int LSW = 3;
  localparam int EXD = 2048;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req_valid;
  logic           req_ready;
  logic [AW-1:0]  req_addr;
  logic [CW-1:0]  req_count;
  logic [CW-1:0]  cfg_burst_bytes;
  logic [LSW-1:0] cfg_line_sel;
  logic [CW-1:0]  cfg_inv_thresh;
  logic           cfg_inv_en_dev;
  logic           cfg_inv_en_bus;
  logic           bst_valid;
  logic           bst_ready;
  logic [3:0]     bst_cmd;
  logic [AW-1:0]  bst_addr;
  logic [CW-1:0]  bst_len;
  logic           bst_last;

  always #2 clk = ~clk;

  wbs_seq #(.AW(AW), .CW(CW), .LSW(LSW)) u_wbs_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_count(req_count),
    .cfg_burst_bytes(cfg_burst_bytes), .cfg_line_sel(cfg_line_sel), .cfg_inv_thresh(cfg_inv_thresh),
    .cfg_inv_en_dev(cfg_inv_en_dev), .cfg_inv_en_bus(cfg_inv_en_bus),
    .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_cmd(bst_cmd),
    .bst_addr(bst_addr), .bst_len(bst_len), .bst_last(bst_last)
  );

  int n_chk = 0;
  int n_bad = 0;

  int rq_addr [8];
  int rq_cnt  [8];
  int n_rq;

  int ex_cmd  [EXD];
  int ex_addr [EXD];
  int ex_len  [EXD];
  int ex_last [EXD];
  int n_ex;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push_ex(input int c, input int a, input int l, input int lst);
    if (n_ex < EXD) begin
      ex_cmd[n_ex] = c; ex_addr[n_ex] = a; ex_len[n_ex] = l; ex_last[n_ex] = lst;
      n_ex++;
    end
  endtask

  // Expected burst list from R2..R8 with the current configuration.
  task automatic build_expected();
    int line, mask, whole, a, r, off, len, c;
    bit ok;
    n_ex  = 0;
    line  = 1 << int'(cfg_line_sel);
    mask  = line - 1;
    whole = int'(cfg_burst_bytes) & ~mask;
    ok    = cfg_inv_en_dev && cfg_inv_en_bus;
    for (int i = 0; i < n_rq; i++) begin
      a = rq_addr[i];
      r = rq_cnt[i];
      while (r > 0) begin
        off = a & mask;
        if (off != 0) begin
          c = 7; len = (line - off < r) ? line - off : r;
        end else if (ok && whole != 0 && r > int'(cfg_inv_thresh) && r >= whole) begin
          c = 15; len = whole;
        end else begin
          c = 7; len = r;
        end
        push_ex(c, a, len, (len == r) ? 1 : 0);
        a = a + len;
        r = r - len;
      end
    end
  endtask

  task automatic set_cfg(input int ls, input int bb, input int th, input bit e1, input bit e2);
    cfg_line_sel    = LSW'(ls);
    cfg_burst_bytes = CW'(bb);
    cfg_inv_thresh  = CW'(th);
    cfg_inv_en_dev  = e1;
    cfg_inv_en_bus  = e2;
  endtask

  task automatic run_seq(input int ready_pct, input bit scramble, input bit use_model,
                         input string tag);
    int  nr, k, cyc;
    bit  acc, gap_chk, hold_chk, scr_pend;
    logic [3:0]    h_cmd;
    logic [AW-1:0] h_addr;
    logic [CW-1:0] h_len;
    logic          h_last;
    if (use_model) build_expected();
    nr = 0; k = 0; cyc = 0; gap_chk = 0; hold_chk = 0; scr_pend = 0;
    h_cmd = '0; h_addr = '0; h_len = '0; h_last = 1'b0;
    while ((nr < n_rq || k < n_ex) && cyc < 20000) begin
      @(negedge clk);
      if (scr_pend) begin
        set_cfg(int'($urandom % 8), int'($urandom % 512), int'($urandom % 512),
                1'($urandom), 1'($urandom));
        scr_pend = 0;
      end
      bst_ready = (int'($urandom % 100) < ready_pct);
      req_valid = (nr < n_rq);
      if (nr < n_rq) begin
        req_addr  = AW'(rq_addr[nr]);
        req_count = CW'(rq_cnt[nr]);
      end
      #1;
      if (gap_chk) begin
        chk(bst_valid, "R10", "no burst right after back-to-back accept", longint'(bst_valid), 1);
        gap_chk = 0;
      end
      if (hold_chk) begin
        chk(bst_valid && bst_cmd == h_cmd && bst_addr == h_addr && bst_len == h_len
            && bst_last == h_last, "R9", "burst changed under back-pressure",
            longint'(bst_addr), longint'(h_addr));
        hold_chk = 0;
      end
      acc = req_valid && req_ready;
      if (bst_valid && !bst_ready) begin
        hold_chk = 1;
        h_cmd = bst_cmd; h_addr = bst_addr; h_len = bst_len; h_last = bst_last;
      end
      if (bst_valid && bst_ready) begin
        if (k >= n_ex) begin
          chk(0, "R8", "extra burst", longint'(bst_addr), 0);
        end else begin
          chk(int'(bst_cmd) == ex_cmd[k], tag, "cmd", longint'(bst_cmd), longint'(ex_cmd[k]));
          chk(bst_addr == AW'(ex_addr[k]), tag, "addr", longint'(bst_addr), longint'(ex_addr[k]));
          chk(bst_len == CW'(ex_len[k]), tag, "len", longint'(bst_len), longint'(ex_len[k]));
          chk(int'(bst_last) == ex_last[k], "R8", "last flag", longint'(bst_last),
              longint'(ex_last[k]));
          k++;
        end
        if (bst_last && nr < n_rq)
          chk(req_ready, "R10", "req_ready on final burst", longint'(req_ready), 1);
        if (bst_last && acc && rq_cnt[nr] != 0) gap_chk = 1;
      end
      @(posedge clk);
      if (acc) begin
        nr++;
        if (scramble) scr_pend = 1;
      end
      cyc++;
    end
    if (cyc >= 20000) chk(0, tag, "sequence hung", longint'(k), longint'(n_ex));
    @(negedge clk);
    req_valid = 1'b0;
    bst_ready = 1'b1;
    #1;
    chk(!bst_valid, "R8", "burst after final one", longint'(bst_valid), 0);
    chk(req_ready, "R10", "idle req_ready", longint'(req_ready), 1);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL WATCHDOG actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; bst_ready = 1'b0;
    req_addr = '0; req_count = '0;
    set_cfg(5, 64, 16, 1, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!bst_valid, "R12", "bst_valid after reset", longint'(bst_valid), 0);
    chk(req_ready, "R12", "req_ready after reset", longint'(req_ready), 1);

    // R2 R4 R5: worked example, 32-byte lines, 64-byte bursts, threshold 16
    set_cfg(5, 64, 16, 1, 1);
    n_rq = 1; rq_addr[0] = 'h1004; rq_cnt[0] = 100;
    n_ex = 0;
    push_ex(7,  'h1004, 28, 0);
    push_ex(15, 'h1020, 64, 0);
    push_ex(7,  'h1060, 8,  1);
    run_seq(100, 0, 0, "R2");

    // R3: aligned start skips the alignment burst
    set_cfg(5, 64, 32, 1, 1);
    n_rq = 1; rq_addr[0] = 'h2000; rq_cnt[0] = 200;
    run_seq(100, 0, 1, "R3");

    // R2: request ends before the first boundary
    set_cfg(5, 64, 0, 1, 1);
    n_rq = 1; rq_addr[0] = 'h3001; rq_cnt[0] = 5;
    run_seq(100, 0, 1, "R2");

    // R6: each enable alone blocks write-and-invalidate
    set_cfg(5, 64, 0, 0, 1);
    n_rq = 1; rq_addr[0] = 'h4010; rq_cnt[0] = 300;
    run_seq(100, 0, 1, "R6");
    set_cfg(5, 64, 0, 1, 0);
    run_seq(70, 0, 1, "R6");

    // R7: burst shorter than a line
    set_cfg(5, 16, 0, 1, 1);
    n_rq = 1; rq_addr[0] = 'h5000; rq_cnt[0] = 160;
    run_seq(100, 0, 1, "R7");

    // R4: 100-byte burst rounds to 96 with 32-byte lines
    set_cfg(5, 100, 0, 1, 1);
    n_rq = 1; rq_addr[0] = 'h6008; rq_cnt[0] = 400;
    run_seq(100, 0, 1, "R4");

    // R5: remaining exactly equal to the threshold goes plain
    set_cfg(5, 32, 32, 1, 1);
    n_rq = 1; rq_addr[0] = 'h7000; rq_cnt[0] = 96;
    run_seq(100, 0, 1, "R5");

    // R8: write-and-invalidate consumes everything, no trailing write
    set_cfg(6, 64, 0, 1, 1);
    n_rq = 1; rq_addr[0] = 'h8000; rq_cnt[0] = 64;
    run_seq(100, 0, 1, "R8");

    // R11: zero count alone, then zero count between transfers
    set_cfg(4, 32, 8, 1, 1);
    n_rq = 1; rq_addr[0] = 'h9000; rq_cnt[0] = 0;
    run_seq(100, 0, 1, "R11");
    repeat (3) begin
      @(negedge clk); #1;
      chk(!bst_valid, "R11", "burst from zero count", longint'(bst_valid), 0);
    end
    n_rq = 3;
    rq_addr[0] = 'h9100; rq_cnt[0] = 50;
    rq_addr[1] = 'h9200; rq_cnt[1] = 0;
    rq_addr[2] = 'h9303; rq_cnt[2] = 70;
    run_seq(100, 0, 1, "R11");

    // R10: back-to-back requests at full rate
    set_cfg(3, 24, 10, 1, 1);
    n_rq = 3;
    rq_addr[0] = 'hA001; rq_cnt[0] = 40;
    rq_addr[1] = 'hA100; rq_cnt[1] = 33;
    rq_addr[2] = 'hA207; rq_cnt[2] = 1;
    run_seq(100, 0, 1, "R10");

    // R9: heavy back-pressure
    set_cfg(4, 48, 20, 1, 1);
    n_rq = 2;
    rq_addr[0] = 'hB00C; rq_cnt[0] = 150;
    rq_addr[1] = 'hB400; rq_cnt[1] = 90;
    run_seq(25, 0, 1, "R9");

    // R13: configuration scrambled after acceptance
    set_cfg(5, 64, 16, 1, 1);
    n_rq = 1; rq_addr[0] = 'hC010; rq_cnt[0] = 250;
    run_seq(60, 1, 1, "R13");

    // R1: random configurations and request mixes
    for (int t = 0; t < 60; t++) begin
      set_cfg(2 + int'($urandom % 6), int'($urandom % 300), int'($urandom % 200),
              ($urandom % 4) != 0, ($urandom % 4) != 0);
      n_rq = 1 + int'($urandom % 3);
      for (int i = 0; i < n_rq; i++) begin
        rq_addr[i] = int'($urandom % 32'h100000);
        rq_cnt[i]  = (($urandom % 8) == 0) ? 0 : int'($urandom % 400);
      end
      run_seq(40 + int'($urandom % 61), 0, 1, "R1");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule